// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a simple synchronous host port to a byte-wide asynchronous static memory with 20 address lines and 8 data lines. The host raises a request with an address, a direction flag and, for writes, a data byte. The controller then drives the memory address, the active-low chip, output and write strobes and the data bus. Each phase of the memory cycle lasts a whole number of clock cycles. Those counts are computed from nanosecond minimums and a clock-period parameter.

Each transaction starts with one address phase in which the address is presented and every strobe is high. A read holds chip and output enable low until both the address access time and the output-enable access time have passed. The data bus is sampled on the last edge of that window. A write holds chip and write enable low for the longer of the pulse-width and data-setup minimums, with output enable high throughout. Write enable is then released one cycle before chip enable, so the write ends on write enable. A recovery period follows. Completion is signalled to the host by a one-cycle ready pulse. A protect input forces every strobe inactive, abandons any transaction in progress and blocks new requests.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is active and after its release, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0 and ready is 0.
- R2: An accepted request puts its address on mem_addr for one cycle with all strobes at 1 before any strobe goes low, and mem_addr does not change while mem_ce_n is 0.
- R3: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for RD cycles, where RD is the largest of ceil(tACC/P), ceil(tOE/P), ceil(tRC/P)-1 and 1. With the defaults (tACC 70 ns, tOE 35 ns, tRC 70 ns, P 10 ns) this gives 7. mem_dq_in is sampled on the last edge of that window and appears on rdata.
- R4: A write holds mem_ce_n=0, mem_we_n=0 and mem_oe_n=1 for WP cycles, where WP is the larger of ceil(tWP/P) and ceil(tDS/P). With the defaults (55 ns and 30 ns) this gives 6. During those cycles mem_dq_oe is 1 and mem_dq_out carries the request data.
- R5: After the write pulse, mem_we_n goes to 1 while mem_ce_n stays 0 and the data stays driven for one cycle. All strobes are then 1 for REC cycles, where REC is the largest of ceil(tWR/P), ceil(tWC/P)-2-WP and 1. With the defaults this gives 1.
- R6: mem_oe_n is 1 whenever mem_we_n is 0 or mem_dq_oe is 1.
- R7: mem_dq_oe is 1 only during the write pulse and the following hold cycle. After a read, one cycle with all strobes at 1 comes before the next address phase, so at least two cycles pass between mem_oe_n rising and mem_dq_oe rising.
- R8: ready is a one-cycle pulse. For a read it comes in the cycle after the data sample. For a write it comes in the cycle after recovery ends. A request present in a cycle where ready is 1 is not accepted.
- R9: While protect is 1, all strobes are 1 and mem_dq_oe is 0 in that same cycle, no request is accepted, and a transaction in progress is dropped without a ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| protect | input | 1 | Forces strobes inactive and blocks requests |
| req | input | 1 | Host request, held until ready |
| wr | input | 1 | 1 selects a write, 0 a read |
| addr | input | 20 | Host byte address |
| wdata | input | 8 | Host write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid from the ready pulse |
| mem_addr | output | 20 | Memory address bus |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tristate enable for mem_dq_out |
| mem_dq_in | input | 8 | Data returned by the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The assertions rely on two properties of the host and memory. First, protect is sampled synchronously. Second, the host holds req, wr, addr and wdata steady from the request until ready, and does not start a new request in the ready cycle except where the bench deliberately tests that case. The bench raises a request only when its reference trace shows the controller idle. It lowers req in the cycle where ready is seen, changes protect only on the falling clock edge, and drives mem_dq_in from a memory model that returns data only while chip and output enable are low and write enable is high. The dropped write leaves its address unknown in the memory model, so it is never read back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_READ,
    PH_TURN,
    PH_WRITE,
    PH_HOLD,
    PH_RECOV
  } phase_t;

  function automatic int ns_to_cyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                 cnt_d = load_val;
    else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC  = 7,
  parameter int WP_CYC  = 6,
  parameter int REC_CYC = 1,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          protect,
  input  logic          req,
  input  logic          wr,
  input  logic          ready_busy,
  input  logic          t_done,
  output phase_t        phase,
  output logic          accept,
  output logic          capture,
  output logic          finish,
  output logic          t_load,
  output logic [CW-1:0] t_val
);

  phase_t phase_q, phase_d;
  logic   wr_q;

  always_comb begin
    phase_d = phase_q;
    accept  = 1'b0;
    capture = 1'b0;
    finish  = 1'b0;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req && !ready_busy) begin
          accept  = 1'b1;
          phase_d = PH_ADDR;
        end
      end
      PH_ADDR: begin
        t_load = 1'b1;
        if (wr_q) begin
          phase_d = PH_WRITE;
          t_val   = CW'(WP_CYC - 1);
        end else begin
          phase_d = PH_READ;
          t_val   = CW'(RD_CYC - 1);
        end
      end
      PH_READ: begin
        if (t_done) begin
          capture = 1'b1;
          phase_d = PH_TURN;
        end
      end
      PH_TURN:  phase_d = PH_IDLE;
      PH_WRITE: begin
        if (t_done) phase_d = PH_HOLD;
      end
      PH_HOLD: begin
        phase_d = PH_RECOV;
        t_load  = 1'b1;
        t_val   = CW'(REC_CYC - 1);
      end
      PH_RECOV: begin
        if (t_done) begin
          finish  = 1'b1;
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    if (protect) begin
      phase_d = PH_IDLE;
      accept  = 1'b0;
      capture = 1'b0;
      finish  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (accept) wr_q <= wr;
    end
  end

  assign phase = phase_q;

  // R9: a protect cycle always leaves the sequencer idle
  a_r9_protect_idles: assert property (@(posedge clk) disable iff (!rst_n)
    protect |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic          finish,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q,
  output logic          ready_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ready_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= bus_rdata;
      ready_q <= capture | finish;
    end
  end

  // R8: completion pulse never lasts two cycles
  a_r8_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> !ready_q);

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW            = 20,
  parameter int DW            = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_ACC_NS      = 70,
  parameter int T_OE_NS       = 35,
  parameter int T_RC_NS       = 70,
  parameter int T_WP_NS       = 55,
  parameter int T_DS_NS       = 30,
  parameter int T_WR_NS       = 5,
  parameter int T_WC_NS       = 70
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          protect,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n
);

  localparam int RD_CYC  = imax(imax(ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_OE_NS, CLK_PERIOD_NS)),
                                imax(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS) - 1, 1));
  localparam int WP_CYC  = imax(imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_DS_NS, CLK_PERIOD_NS)), 1);
  localparam int REC_CYC = imax(imax(ns_to_cyc(T_WR_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - 2 - WP_CYC), 1);
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), REC_CYC);
  localparam int CW      = $clog2(MAX_CYC + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  phase_t        phase;
  logic          accept, capture, finish, t_load, t_done, ready_q;
  logic [CW-1:0] t_val;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  sram_ctrl_fsm #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC),
    .CW     (CW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .protect   (protect),
    .req       (req),
    .wr        (wr),
    .ready_busy(ready_q),
    .t_done    (t_done),
    .phase     (phase),
    .accept    (accept),
    .capture   (capture),
    .finish    (finish),
    .t_load    (t_load),
    .t_val     (t_val)
  );

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (t_load),
    .load_val(t_val),
    .done    (t_done)
  );

  sram_ctrl_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .accept   (accept),
    .capture  (capture),
    .finish   (finish),
    .req_addr (addr),
    .req_wdata(wdata),
    .bus_rdata(mem_dq_in),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q),
    .rdata_q  (rdata_q),
    .ready_q  (ready_q)
  );

  logic live;
  assign live       = rst_sync_n && !protect;
  assign mem_ce_n   = !(live && (phase == PH_READ || phase == PH_WRITE || phase == PH_HOLD));
  assign mem_oe_n   = !(live && (phase == PH_READ));
  assign mem_we_n   = !(live && (phase == PH_WRITE));
  assign mem_dq_oe  = live && (phase == PH_WRITE || phase == PH_HOLD);
  assign mem_dq_out = wdata_q;
  assign mem_addr   = addr_q;
  assign ready      = ready_q;
  assign rdata      = rdata_q;

  // consecutive write-low cycles, for the pulse width check
  logic [CW:0] we_low_cnt;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                        we_low_cnt <= '0;
    else if (mem_we_n)                      we_low_cnt <= '0;
    else if (we_low_cnt != {(CW+1){1'b1}})  we_low_cnt <= we_low_cnt + 1'b1;
  end

  // R6: no output enable while writing or driving
  a_r6_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mem_we_n || mem_dq_oe) |-> mem_oe_n);

  // R2: address frozen while the chip is selected
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R4: a write pulse ending normally is at least WP cycles long
  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(mem_we_n) && !protect) |-> (we_low_cnt >= (CW+1)'(WP_CYC)));

  // R7: driving starts only after two cycles with output enable high
  a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n, 1) && $past(mem_oe_n, 2)));

  // R5: write enable rises while chip enable stays low (write ends on WE)
  a_r5_we_ends_cycle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(mem_we_n) && !protect) |-> (!mem_ce_n && mem_dq_oe));

endmodule

// File: tb/sram_bus_ctrl_tb.sv
module sram_bus_ctrl_tb;

  localparam int CLK_NS = 10;
  localparam int RD_N   = 7;   // max(ceil(70/10), ceil(35/10), ceil(70/10)-1)
  localparam int WP_N   = 6;   // max(ceil(55/10), ceil(30/10))
  localparam int REC_N  = 1;   // max(ceil(5/10), 7-2-6, 1)

  logic        clk = 1'b0;
  logic        rst_n, protect, req, wr;
  logic [19:0] addr;
  logic [7:0]  wdata, rdata, mem_dq_out, mem_dq_in;
  logic        ready, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
  logic [19:0] mem_addr;

  always #(CLK_NS/2) clk = ~clk;

  sram_bus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .protect(protect), .req(req), .wr(wr),
    .addr(addr), .wdata(wdata), .ready(ready), .rdata(rdata),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n)
  );

  // memory model
  logic [7:0] mem [0:255];
  logic [7:0] ref_mem [0:255];
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mem[mem_addr[7:0]] : 8'h00;
  always @(posedge mem_we_n) if (mem_ce_n === 1'b0) mem[mem_addr[7:0]] <= mem_dq_out;

  int tests = 0, fails = 0;
  bit finished = 0;

  // expected trace entry: {addr_check, ce_n, oe_n, we_n, dq_oe, ready}
  logic [5:0]  trace [$];
  logic [19:0] cur_addr;
  logic [7:0]  cur_wdata;
  bit          cur_wr;
  bit          saw_ready;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [5:0] e;
    @(negedge clk);
    e = (trace.size() != 0) ? trace.pop_front() : 6'b011100;
    chk("R2/R3/R4/R5/R9 ce_n", 32'(mem_ce_n), 32'(e[4]));
    chk("R3/R6 oe_n",          32'(mem_oe_n), 32'(e[3]));
    chk("R4/R5 we_n",          32'(mem_we_n), 32'(e[2]));
    chk("R7 dq_oe",            32'(mem_dq_oe), 32'(e[1]));
    chk("R8 ready",            32'(ready),    32'(e[0]));
    if (e[5]) chk("R2 mem_addr", 32'(mem_addr), 32'(cur_addr));
    if (e[1]) chk("R4 dq_out",   32'(mem_dq_out), 32'(cur_wdata));
    saw_ready = ready;
    if (e[0] && !cur_wr) chk("R3 rdata", 32'(rdata), 32'(ref_mem[cur_addr[7:0]]));
  endtask

  task automatic start(input bit w, input logic [19:0] a, input logic [7:0] d);
    req = 1'b1; wr = w; addr = a; wdata = d;
    cur_wr = w; cur_addr = a; cur_wdata = d;
    trace.push_back(6'b111100);
    if (w) begin
      for (int i = 0; i < WP_N; i++) trace.push_back(6'b101010);
      trace.push_back(6'b101110);
      for (int i = 0; i < REC_N; i++) trace.push_back(6'b111100);
      trace.push_back(6'b011101);
      ref_mem[a[7:0]] = d;
    end else begin
      for (int i = 0; i < RD_N; i++) trace.push_back(6'b100100);
      trace.push_back(6'b111101);
    end
  endtask

  task automatic wait_ready(input bit keep_req);
    saw_ready = 0;
    for (int i = 0; i < 40 && !saw_ready; i++) tick();
    if (!saw_ready) chk("R8 ready timeout", 0, 1);
    if (!keep_req) req = 1'b0;
  endtask

  task automatic xact(input bit w, input logic [19:0] a, input logic [7:0] d);
    start(w, a, d);
    wait_ready(0);
    tick();
  endtask

  initial begin
    #(CLK_NS * 20000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      ref_mem[i] = 8'(i) ^ 8'h5A;
    end
    rst_n = 1'b0; protect = 1'b0; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    cur_addr = '0; cur_wdata = '0; cur_wr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ce_n",  32'(mem_ce_n), 1);
    chk("R1 oe_n",  32'(mem_oe_n), 1);
    chk("R1 we_n",  32'(mem_we_n), 1);
    chk("R1 dq_oe", 32'(mem_dq_oe), 0);
    chk("R1 ready", 32'(ready), 0);
    rst_n = 1'b1;
    repeat (4) tick();

    // basic write then read back
    xact(1, 20'hA5512, 8'hC3);
    xact(0, 20'hA5512, 8'h00);
    // untouched location
    xact(0, 20'h00077, 8'h00);
    // extreme data values, high address bits
    xact(1, 20'hFFF01, 8'hFF);
    xact(1, 20'h80002, 8'h00);
    xact(0, 20'hFFF01, 8'h00);
    xact(0, 20'h80002, 8'h00);

    // R7: read followed at once by a write, turnaround checked per cycle
    xact(0, 20'h00033, 8'h00);
    xact(1, 20'h00034, 8'h96);
    xact(0, 20'h00034, 8'h00);

    // R8: request held through the ready cycle is not taken then
    start(1, 20'h12345, 8'h3C);
    wait_ready(1);
    wr = 1'b0;
    tick();                       // idle expected: held request ignored
    start(0, 20'h12345, 8'h00);   // now taken as a read of the new data
    wait_ready(0);
    tick();

    // R9: protect holds off a pending request
    @(negedge clk);
    trace.delete();
    protect = 1'b1; req = 1'b1; wr = 1'b1; addr = 20'h00050; wdata = 8'h11;
    #1;
    chk("R9 ce_n under protect", 32'(mem_ce_n), 1);
    chk("R9 dq_oe under protect", 32'(mem_dq_oe), 0);
    repeat (5) tick();            // idle expected throughout
    protect = 1'b0;
    start(1, 20'h00050, 8'h11);
    wait_ready(0);
    tick();
    xact(0, 20'h00050, 8'h00);

    // R9: protect during a write pulse drops the transaction, no ready
    start(1, 20'h00060, 8'hE7);
    repeat (3) tick();
    protect = 1'b1;
    #1;
    chk("R9 we_n forced high", 32'(mem_we_n), 1);
    chk("R9 ce_n forced high", 32'(mem_ce_n), 1);
    chk("R9 dq_oe forced low", 32'(mem_dq_oe), 0);
    trace.delete();
    req = 1'b0;
    repeat (4) tick();            // idle with ready 0 expected
    protect = 1'b0;
    repeat (2) tick();
    xact(0, 20'h00070, 8'h00);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule